// File: doc/BRIEF.md
# Round-Robin Warp Scheduler

This block decides which warp of a multi-warp SIMT core issues the next instruction fetch. It holds one stall bit per warp. It also receives a vector that marks which warps still have live threads. On each cycle in which fetch can accept a new choice, it scans the warps in circular order. The scan begins with the warp just after the last one chosen. The first warp found that is both live and not stalled becomes the registered selection.

The fetch stage raises a stall request when it has just fetched a control-flow instruction, such as a branch, a jump, a divergence split, a thread-mask change or a barrier. That warp then stays out of the rotation. The writeback stage sends a release request once the stalling instruction retires. A release only changes the stall bit at the clock edge. A search in the same cycle still treats the warp as stalled.

When no warp qualifies, the valid flag drops and the previous warp id is kept. The next search therefore resumes from the same place.

Top module: `warp_rr_sched`

## Requirements
- R1: On a cycle with `fetch_ready` high, the scan visits warp ids base+1, base+2, ... modulo NUM_WARPS. Here base is the current `sel_warp`, so the current warp is examined last. The first warp whose `warp_active` bit is 1 and which is not stalled is loaded into `sel_warp`, and `sel_valid` is set to 1.
- R2: If the scan finds no qualifying warp, `sel_valid` becomes 0 and `sel_warp` keeps its value.
- R3: A stall request (`stall_req`=1, id `stall_req_id`) removes that warp from the scan of the same cycle. The warp stays out of every later scan until it is released. The request is accepted whether or not `fetch_ready` is high.
- R4: A release request (`release_req`=1, id `release_req_id`) clears the stall bit at the end of the cycle. The scan in that same cycle still skips the warp.
- R5: While `rst_n` is low, and after it rises: `sel_warp` is 0, `sel_valid` is 1 and no warp is stalled.
- R6: With `fetch_ready` low, `sel_warp` and `sel_valid` keep their values.
- R7: A stall request and a release request for the same warp in the same cycle leave that warp not stalled afterwards. The warp is still skipped by that cycle's scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_ready | input | 1 | Fetch can take a new warp this cycle (no downstream stall, no pending fetch wait) |
| warp_active | input | NUM_WARPS | Bit i is 1 when warp i has at least one live thread |
| stall_req | input | 1 | Fetch found a control-flow instruction in warp `stall_req_id` |
| stall_req_id | input | IDW | Warp to stall |
| release_req | input | 1 | Writeback retired the stalling instruction of warp `release_req_id` |
| release_req_id | input | IDW | Warp to release |
| sel_warp | output | IDW | Registered id of the selected warp |
| sel_valid | output | 1 | Registered flag: the last scan found a warp |

## Verification
Every result of a scan appears on `sel_warp` and `sel_valid` one rising edge after the inputs of that cycle. A stall or release changes the stall bit at that same edge, so its effect shows up in the selection made one cycle later. The bench changes inputs on the falling edge and samples the outputs 1 ns after the following rising edge. Each check therefore sees exactly the cycle it describes. The same-cycle cases (a stall hiding a warp at once, a release that does not help yet) are laid out as consecutive table rows.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
   localparam int MAX_WARPS = 32;

   function automatic int id_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/wsched_stall_reg.sv
module wsched_stall_reg #(
   parameter int NUM_WARPS = 8,
   localparam int IDW = wsched_pkg::id_bits(NUM_WARPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [IDW-1:0]       set_id,
   input  logic                 rel_en,
   input  logic [IDW-1:0]       rel_id,
   output logic [NUM_WARPS-1:0] stall_q,
   output logic [NUM_WARPS-1:0] stall_now
);
   localparam logic [IDW:0] NW = (IDW+1)'(NUM_WARPS);

   logic [NUM_WARPS-1:0] set_vec, rel_vec;

   always_comb begin
      for (int i = 0; i < NUM_WARPS; i++) begin
         set_vec[i] = set_en && (set_id == IDW'(i));
         rel_vec[i] = rel_en && (rel_id == IDW'(i));
      end
   end

   // a fresh stall hides the warp at once; a release waits for the edge
   assign stall_now = stall_q | set_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stall_q <= '0;
      else        stall_q <= (stall_q | set_vec) & ~rel_vec;
   end

   // R3: stall without a matching release sticks
   a_r3_stall_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && ({1'b0, set_id} < NW) && !(rel_en && rel_id == set_id))
      |=> stall_q[$past(set_id)]);

   // R7 / R4: a release always leaves the warp free after the edge
   a_r7_release_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_en && ({1'b0, rel_id} < NW)) |=> !stall_q[$past(rel_id)]);
endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
   parameter int NUM_WARPS = 8,
   localparam int IDW = wsched_pkg::id_bits(NUM_WARPS)
) (
   input  logic [IDW-1:0]       base,
   input  logic [NUM_WARPS-1:0] elig,
   output logic                 hit,
   output logic [IDW-1:0]       pick
);
   localparam bit POW2 = wsched_pkg::is_pow2(NUM_WARPS);

   // cand[k] = (base + k + 1) mod NUM_WARPS
   logic [IDW-1:0] cand [NUM_WARPS];

   generate
      if (POW2) begin : g_pow2
         for (genvar k = 0; k < NUM_WARPS; k++) begin : g_off
            assign cand[k] = base + IDW'(k + 1);
         end
      end else begin : g_mod
         for (genvar k = 0; k < NUM_WARPS; k++) begin : g_off
            logic [IDW:0] sum;
            assign sum     = {1'b0, base} + (IDW+1)'(k + 1);
            assign cand[k] = (sum >= (IDW+1)'(NUM_WARPS))
                           ? IDW'(sum - (IDW+1)'(NUM_WARPS)) : sum[IDW-1:0];
         end
      end
   endgenerate

   always_comb begin
      hit  = 1'b0;
      pick = base;
      for (int k = NUM_WARPS - 1; k >= 0; k--) begin
         if (elig[cand[k]]) begin
            hit  = 1'b1;
            pick = cand[k];
         end
      end
   end
endmodule

// File: rtl/warp_rr_sched.sv
module warp_rr_sched #(
   parameter int NUM_WARPS = 8,
   localparam int IDW = wsched_pkg::id_bits(NUM_WARPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fetch_ready,
   input  logic [NUM_WARPS-1:0] warp_active,
   input  logic                 stall_req,
   input  logic [IDW-1:0]       stall_req_id,
   input  logic                 release_req,
   input  logic [IDW-1:0]       release_req_id,
   output logic [IDW-1:0]       sel_warp,
   output logic                 sel_valid
);
   generate
      if (NUM_WARPS < 2 || NUM_WARPS > wsched_pkg::MAX_WARPS) begin : g_bad
         $error("warp_rr_sched: NUM_WARPS out of range 2..32");
      end
   endgenerate

   logic [NUM_WARPS-1:0] stall_q, stall_now, elig;
   logic                 pick_hit;
   logic [IDW-1:0]       pick_id;

   wsched_stall_reg #(.NUM_WARPS(NUM_WARPS)) u_stall (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (stall_req),
      .set_id    (stall_req_id),
      .rel_en    (release_req),
      .rel_id    (release_req_id),
      .stall_q   (stall_q),
      .stall_now (stall_now)
   );

   assign elig = warp_active & ~stall_now;

   wsched_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
      .base (sel_warp),
      .elig (elig),
      .hit  (pick_hit),
      .pick (pick_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_warp  <= '0;
         sel_valid <= 1'b1;
      end else if (fetch_ready) begin
         sel_valid <= pick_hit;
         if (pick_hit) sel_warp <= pick_id;
      end
   end

   // R1: a chosen warp is live and not stalled
   a_r1_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      pick_hit |-> (warp_active[pick_id] && !stall_q[pick_id]
                    && !(stall_req && stall_req_id == pick_id)));

   // R2: an empty scan drops the flag and keeps the id
   a_r2_none_found: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_ready && !pick_hit) |=> (!sel_valid && $stable(sel_warp)));

   // R6: no new choice while fetch is busy
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_ready |=> ($stable(sel_warp) && $stable(sel_valid)));

   // R2: a miss only happens when no warp qualifies
   a_r2_miss_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !pick_hit |-> ((warp_active & ~stall_now) == '0));
endmodule

// File: tb/sim_warp_rr_sched.sv
module sim_warp_rr_sched;
   localparam int N   = 4;
   localparam int IDW = 2;
   localparam int NV  = 18;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           fetch_ready = 1'b0;
   logic [N-1:0]   warp_active = '0;
   logic           stall_req = 1'b0;
   logic [IDW-1:0] stall_req_id = '0;
   logic           release_req = 1'b0;
   logic [IDW-1:0] release_req_id = '0;
   logic [IDW-1:0] sel_warp;
   logic           sel_valid;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   warp_rr_sched #(.NUM_WARPS(N)) u0 (
      .clk(clk), .rst_n(rst_n), .fetch_ready(fetch_ready),
      .warp_active(warp_active), .stall_req(stall_req),
      .stall_req_id(stall_req_id), .release_req(release_req),
      .release_req_id(release_req_id), .sel_warp(sel_warp),
      .sel_valid(sel_valid)
   );

   // {ready, active[3:0], stall, stall_id, rel, rel_id, exp_id, exp_valid}
   localparam logic [13:0] VEC [NV] = '{
      {1'b1, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b1}, // R1 0->1
      {1'b1, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 2'd2, 1'b1}, // R1 1->2
      {1'b1, 4'b1011, 1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 1'b1}, // R1 2->3
      {1'b1, 4'b1010, 1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b1}, // R1 wrap 3->1
      {1'b1, 4'b1111, 1'b1, 2'd2, 1'b0, 2'd0, 2'd3, 1'b1}, // R3 stall 2 skipped now
      {1'b1, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b1}, // R3 3->0
      {1'b1, 4'b0100, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0}, // R2 only stalled live
      {1'b1, 4'b0100, 1'b0, 2'd0, 1'b1, 2'd2, 2'd0, 1'b0}, // R4 release not seen yet
      {1'b1, 4'b0100, 1'b0, 2'd0, 1'b0, 2'd0, 2'd2, 1'b1}, // R4 released
      {1'b0, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 2'd2, 1'b1}, // R6 hold
      {1'b1, 4'b1111, 1'b1, 2'd3, 1'b1, 2'd3, 2'd0, 1'b1}, // R7 3 skipped this cycle
      {1'b1, 4'b1000, 1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 1'b1}, // R7 3 free afterwards
      {1'b1, 4'b1000, 1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 1'b1}, // R1 self examined last
      {1'b0, 4'b1000, 1'b1, 2'd3, 1'b0, 2'd0, 2'd3, 1'b1}, // R3 stall while busy
      {1'b1, 4'b1000, 1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 1'b0}, // R3 stall took effect
      {1'b0, 4'b1000, 1'b0, 2'd0, 1'b1, 2'd3, 2'd3, 1'b0}, // R6 hold flag low
      {1'b1, 4'b1000, 1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 1'b1}, // R4 free again
      {1'b1, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 1'b0}  // R2 none live
   };
   localparam int TAG [NV] = '{1,1,1,1,3,3,2,4,4,6,7,7,1,3,3,6,4,2};

   task automatic check(input string req, input logic [IDW-1:0] eid,
                        input logic ev);
      checks++;
      if (sel_warp !== eid || sel_valid !== ev) begin
         errors++;
         $display("FAIL %s: sel_warp=%0d sel_valid=%0b expected %0d/%0b",
                  req, sel_warp, sel_valid, eid, ev);
      end
   endtask

   task automatic step(input logic rdy, input logic [N-1:0] act,
                       input logic s, input logic [IDW-1:0] sid,
                       input logic r, input logic [IDW-1:0] rid);
      @(negedge clk);
      fetch_ready = rdy; warp_active = act;
      stall_req = s; stall_req_id = sid;
      release_req = r; release_req_id = rid;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [13:0] v;
      repeat (3) @(posedge clk);
      #1;
      check("R5 in reset", 2'd0, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R5 after reset", 2'd0, 1'b1);

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         step(v[13], v[12:9], v[8], v[7:6], v[5], v[4:3]);
         check($sformatf("R%0d row %0d", TAG[i], i), v[2:1], v[0]);
      end

      // R5: reset mid-run clears stalls and restores id 0 / valid 1
      step(1'b0, 4'b0010, 1'b1, 2'd1, 1'b0, 2'd0);
      @(negedge clk);
      stall_req = 1'b0;
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check("R5 mid-run reset", 2'd0, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 4'b0010, 1'b0, 2'd0, 1'b0, 2'd0);
      check("R5 stall cleared by reset", 2'd1, 1'b1);

      // R1: only warp 0 live, search wraps past 2 and 3
      step(1'b1, 4'b0001, 1'b0, 2'd0, 1'b0, 2'd0);
      check("R1 wrap to 0", 2'd0, 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule